// File: doc/BRIEF.md
# Isolated-Word Recognition Session Sequencer

This block orders the steps of one isolated-word recognition session. While idle it keeps audio capture into memory enabled. A capture-stop event ends the capture window and raises an interrupt asking the host to extract features. The event is a user switch press in the small-vocabulary flow, or an end-of-voice-activity pulse in the large-vocabulary flow. In the large-vocabulary flow the host also loads the word models into the scorer buffers before it reports completion.

When the host reports completion through its done strobe, the sequencer walks through every word model in index order. For each model it pulses a start for the external scorer, waits for the scorer's done pulse, and issues a write strobe that stores the returned score in the output frame buffer. A running comparison keeps the index of the best score. Once the last model is scored, the sequencer raises a completion flag and the display output carries the winning index. A new session starts only when the user switch is released.

Top module: `recog_seq_ctrl`

## Requirements
- R1: In the cycles after reset, capture_en is 1, and host_irq, score_start, result_wr and session_done are 0.
- R2: The level of mode_sw during reset selects the flow for the session: 0 gives small vocabulary and 1 gives large vocabulary. large_mode shows the selection and keeps that value until the next reset.
- R3: In small-vocabulary mode, vad_end is ignored. A 0-to-1 transition of stop_sw seen after reset ends capture: one cycle later capture_en is 0 and host_irq is 1. A switch that is already high at reset must be released and pressed again to count.
- R4: In large-vocabulary mode, stop_sw is ignored during capture. A vad_end pulse ends capture and raises host_irq one cycle later.
- R5: host_irq stays 1 until host_ack or host_done is seen. host_ack alone drops host_irq and does not start scoring.
- R6: host_done during the interrupt or after an acknowledge starts scoring. One cycle later score_start pulses for one cycle with word_idx 0.
- R7: Each score_done received while waiting produces exactly one result_wr pulse in that same cycle with the current word_idx. The next score_start follows one cycle later with word_idx plus one. Words are visited from 0 to NUM_WORDS-1.
- R8: One cycle after the score_done of word NUM_WORDS-1, session_done is 1. led_word then holds the index of the largest unsigned score, and on a tie the lower index wins.
- R9: session_done stays 1 while stop_sw is held. A 1-to-0 transition of stop_sw clears it and re-enables capture one cycle later.
- R10: score_done outside the scoring wait, and host_done or host_ack during capture, produce no result_wr and do not end capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sw | input | 1 | Vocabulary mode switch, sampled while reset is held |
| stop_sw | input | 1 | User switch: press ends small-vocabulary capture, release starts a new session |
| vad_end | input | 1 | End-of-voice-activity pulse |
| host_ack | input | 1 | Host acknowledges the interrupt |
| host_done | input | 1 | Host finished feature extraction (and model loading) |
| score_done | input | 1 | Scorer finished the current word |
| score_value | input | SCORE_W | Score returned by the scorer, larger is better |
| capture_en | output | 1 | Audio sample storage enable |
| host_irq | output | 1 | Interrupt to the host requesting features |
| large_mode | output | 1 | 1 when the large-vocabulary flow is selected |
| score_start | output | 1 | One-cycle start for the scorer |
| word_idx | output | IDX_W | Word model currently being scored |
| result_wr | output | 1 | Store strobe for the output frame buffer |
| session_done | output | 1 | All words scored |
| led_word | output | IDX_W | Index of the recognised word for the display |

## Verification
The scoring loop is tried with three score sets, each of which separates one part of the comparison. In the first, two equal maxima sit at indices 3 and 7, which exposes a comparison that lets a later tie win. In the second, the maximum sits on the last word, which exposes an off-by-one exit from the loop. In the third, used in large-vocabulary mode, the maximum is at word 0, which exposes an uninitialised best value. The capture-stop paths are tried with the wrong trigger for each mode, with a switch held through reset, and with the acknowledge path and the direct-done path, so that a design using the wrong trigger or re-triggering on a held switch is caught.

// File: rtl/recog_seq_pkg.sv
// Shared types for the recognition session sequencer.
package recog_seq_pkg;
    typedef enum logic [2:0] {
        ST_CAPTURE    = 3'd0,
        ST_IRQ        = 3'd1,
        ST_WAIT_DONE  = 3'd2,
        ST_SCORE_GO   = 3'd3,
        ST_SCORE_WAIT = 3'd4,
        ST_FINISH     = 3'd5
    } seq_state_t;
endpackage

// File: rtl/rs_switch_edge.sv
// Registers the user switch and reports press (0->1) and release (1->0)
// transitions. Assumes the switch is already debounced. The history register
// resets to 1, so a switch held through reset gives no press.
module rs_switch_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sw,
    output logic press,
    output logic release_ev
);
    logic sw_q;

    // Remember last cycle's switch level.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= 1'b1;
        else        sw_q <= sw;
    end

    assign press      = sw & ~sw_q;
    assign release_ev = ~sw & sw_q;
endmodule

// File: rtl/rs_best_tracker.sv
// Running arg-max over the scores of one session. A strictly larger score
// replaces the current best, so on a tie the earlier (lower) index is kept.
// Assumes words arrive in increasing index order.
module rs_best_tracker #(
    parameter int SCORE_W = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               update,
    input  logic [IDX_W-1:0]   idx,
    input  logic [SCORE_W-1:0] score,
    output logic [IDX_W-1:0]   best_idx
);
    logic [SCORE_W-1:0] best_score;
    logic               have_one;

    // Hold the best score and its index; clear at session start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_score <= '0;
            best_idx   <= '0;
            have_one   <= 1'b0;
        end else if (update && (!have_one || score > best_score)) begin
            best_score <= score;
            best_idx   <= idx;
            have_one   <= 1'b1;
        end
    end
endmodule

// File: rtl/rs_seq_fsm.sv
// Session state machine: capture, interrupt the host, wait for the done
// strobe, then score every word model in order and report completion.
// Assumes large_mode is constant outside reset.
module rs_seq_fsm
    import recog_seq_pkg::*;
#(
    parameter int NUM_WORDS = 10,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             large_mode,
    input  logic             sw_press,
    input  logic             sw_release,
    input  logic             vad_end,
    input  logic             host_ack,
    input  logic             host_done,
    input  logic             score_done,
    output logic             capture_en,
    output logic             host_irq,
    output logic             score_start,
    output logic             result_wr,
    output logic             session_done,
    output logic             clear_best,
    output logic [IDX_W-1:0] word_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    seq_state_t state, state_nx;
    logic       stop_trig;
    logic       last_word;

    assign stop_trig = large_mode ? vad_end : sw_press;
    assign last_word = (word_idx == LAST_IDX);
    assign clear_best = ((state == ST_IRQ) || (state == ST_WAIT_DONE)) && host_done;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_CAPTURE:    if (stop_trig) state_nx = ST_IRQ;
            ST_IRQ:        if (host_done) state_nx = ST_SCORE_GO;
                           else if (host_ack) state_nx = ST_WAIT_DONE;
            ST_WAIT_DONE:  if (host_done) state_nx = ST_SCORE_GO;
            ST_SCORE_GO:   state_nx = ST_SCORE_WAIT;
            ST_SCORE_WAIT: if (score_done) state_nx = last_word ? ST_FINISH : ST_SCORE_GO;
            ST_FINISH:     if (sw_release) state_nx = ST_CAPTURE;
            default:       state_nx = ST_CAPTURE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CAPTURE;
        else        state <= state_nx;
    end

    // Word counter: cleared at session start, advanced after each result.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_best)
            word_idx <= '0;
        else if ((state == ST_SCORE_WAIT) && score_done && !last_word)
            word_idx <= word_idx + 1'b1;
    end

    assign capture_en   = (state == ST_CAPTURE);
    assign host_irq     = (state == ST_IRQ);
    assign score_start  = (state == ST_SCORE_GO);
    assign result_wr    = (state == ST_SCORE_WAIT) && score_done;
    assign session_done = (state == ST_FINISH);
endmodule

// File: rtl/recog_seq_ctrl.sv
// Top of the recognition session sequencer. Latches the vocabulary mode while
// reset is held, detects switch transitions, runs the session state machine
// and tracks the best-scoring word for the display.
module recog_seq_ctrl #(
    parameter int NUM_WORDS = 10,
    parameter int SCORE_W   = 16,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sw,
    input  logic               stop_sw,
    input  logic               vad_end,
    input  logic               host_ack,
    input  logic               host_done,
    input  logic               score_done,
    input  logic [SCORE_W-1:0] score_value,
    output logic               capture_en,
    output logic               host_irq,
    output logic               large_mode,
    output logic               score_start,
    output logic [IDX_W-1:0]   word_idx,
    output logic               result_wr,
    output logic               session_done,
    output logic [IDX_W-1:0]   led_word
);
    logic sw_press, sw_release, clear_best;

    // Mode switch is sampled only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) large_mode <= mode_sw;
    end

    rs_switch_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw         (stop_sw),
        .press      (sw_press),
        .release_ev (sw_release)
    );

    rs_seq_fsm #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .large_mode   (large_mode),
        .sw_press     (sw_press),
        .sw_release   (sw_release),
        .vad_end      (vad_end),
        .host_ack     (host_ack),
        .host_done    (host_done),
        .score_done   (score_done),
        .capture_en   (capture_en),
        .host_irq     (host_irq),
        .score_start  (score_start),
        .result_wr    (result_wr),
        .session_done (session_done),
        .clear_best   (clear_best),
        .word_idx     (word_idx)
    );

    rs_best_tracker #(.SCORE_W(SCORE_W), .IDX_W(IDX_W)) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_best),
        .update   (result_wr),
        .idx      (word_idx),
        .score    (score_value),
        .best_idx (led_word)
    );
endmodule

// File: rtl/recog_seq_ctrl_chk.sv
// Protocol checks on the sequencer ports, bound to every instance of the top.
module recog_seq_ctrl_chk #(
    parameter int NUM_WORDS = 10,
    parameter int IDX_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_sw,
    input logic             host_ack,
    input logic             host_done,
    input logic             capture_en,
    input logic             host_irq,
    input logic             large_mode,
    input logic             score_start,
    input logic [IDX_W-1:0] word_idx,
    input logic             result_wr,
    input logic             session_done
);
    // R1: capture never overlaps the interrupt or completion.
    p_capture_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |-> (!host_irq && !session_done));

    // R2: mode holds between resets.
    p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(large_mode));

    // R3/R4: interrupt only rises out of capture.
    p_irq_from_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(capture_en));

    // R5: interrupt held until acknowledged or done.
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !host_ack && !host_done) |=> host_irq);

    // R6: scorer start is a single-cycle pulse.
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        score_start |=> !score_start);

    // R7: results are written only for valid words.
    p_result_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_wr |-> (int'(word_idx) < NUM_WORDS));

    // R9: completion persists while the switch is held.
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (session_done && stop_sw) |=> session_done);
endmodule

bind recog_seq_ctrl recog_seq_ctrl_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_sw      (stop_sw),
    .host_ack     (host_ack),
    .host_done    (host_done),
    .capture_en   (capture_en),
    .host_irq     (host_irq),
    .large_mode   (large_mode),
    .score_start  (score_start),
    .word_idx     (word_idx),
    .result_wr    (result_wr),
    .session_done (session_done)
);

// File: tb/test_recog_seq_ctrl.sv
`timescale 1ns/100ps
module test_recog_seq_ctrl;
    localparam int NW = 10;
    localparam int SW = 16;
    localparam int IW = $clog2(NW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sw = 1'b0, stop_sw = 1'b0, vad_end = 1'b0;
    logic host_ack = 1'b0, host_done = 1'b0, score_done = 1'b0;
    logic [SW-1:0] score_value = '0;
    logic capture_en, host_irq, large_mode, score_start, result_wr, session_done;
    logic [IW-1:0] word_idx, led_word;

    int n_cmp = 0;
    int n_bad = 0;
    int res_count = 0;
    int cyc = 0;
    int exp_idx_q[$];
    int exp_led_q[$];
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    recog_seq_ctrl #(.NUM_WORDS(NW), .SCORE_W(SW)) i_recog_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .stop_sw(stop_sw),
        .vad_end(vad_end), .host_ack(host_ack), .host_done(host_done),
        .score_done(score_done), .score_value(score_value),
        .capture_en(capture_en), .host_irq(host_irq), .large_mode(large_mode),
        .score_start(score_start), .word_idx(word_idx), .result_wr(result_wr),
        .session_done(session_done), .led_word(led_word)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // Monitor: pops expected word indices and winners as the design produces them.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (score_start) begin
                    if (exp_idx_q.size() == 0) check("R7 unexpected start", int'(word_idx), -1);
                    else check("R7 word order", int'(word_idx), exp_idx_q.pop_front());
                end
                if (result_wr) res_count++;
                if (session_done && !done_prev) begin
                    if (exp_led_q.size() == 0) check("R8 unexpected done", int'(led_word), -1);
                    else check("R8 winner", int'(led_word), exp_led_q.pop_front());
                end
            end
            done_prev = rst_n && session_done;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d expected <= 50000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver: queue the expected order and winner for one session.
    task automatic push_session(input int vals[NW]);
        int best = 0;
        for (int w = 0; w < NW; w++) begin
            exp_idx_q.push_back(w);
            if (vals[w] > vals[best]) best = w;
        end
        exp_led_q.push_back(best);
    endtask

    // Behave as the scorer for every word, then check completion.
    task automatic serve_scores(input int vals[NW]);
        res_count = 0;
        for (int w = 0; w < NW; w++) begin
            int guard = 0;
            while (!score_start && guard < 50) begin tick(); guard++; end
            tick(); tick();
            score_done = 1'b1; score_value = SW'(vals[w]);
            tick();
            score_done = 1'b0;
        end
        check("R8 session_done", int'(session_done), 1);
        check("R7 result_wr count", res_count, NW);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; mode_sw = mode;
        repeat (3) tick();
        rst_n = 1'b1; mode_sw = 1'b0;
        tick();
    endtask

    initial begin
        int set_a[NW] = '{5, 9, 2, 40, 7, 1, 3, 40, 6, 8};
        int set_b[NW] = '{10, 20, 30, 40, 50, 60, 70, 80, 90, 95};
        int set_c[NW] = '{900, 5, 4, 3, 2, 899, 1, 0, 7, 8};

        // Reset with the switch held: a held switch must not count as a press.
        stop_sw = 1'b1;
        do_reset(1'b0);
        check("R1 capture_en", int'(capture_en), 1);
        check("R1 host_irq", int'(host_irq), 0);
        check("R1 session_done", int'(session_done), 0);
        check("R1 score_start", int'(score_start), 0);
        check("R2 small mode", int'(large_mode), 0);
        repeat (3) tick();
        check("R3 held switch ignored", int'(capture_en), 1);
        stop_sw = 1'b0; tick();
        check("R3 release during capture ignored", int'(capture_en), 1);

        // Ignored inputs during capture.
        vad_end = 1'b1; tick(); vad_end = 1'b0; tick();
        check("R3 vad_end ignored in small mode", int'(capture_en), 1);
        score_done = 1'b1; host_done = 1'b1; host_ack = 1'b1; #0.5;
        check("R10 no result_wr in capture", int'(result_wr), 0);
        tick(); score_done = 1'b0; host_done = 1'b0; host_ack = 1'b0; tick();
        check("R10 capture kept", int'(capture_en), 1);

        // Session 1: small mode, ack path, tie at 3 and 7.
        push_session(set_a);
        stop_sw = 1'b1; tick();
        check("R3 capture stops", int'(capture_en), 0);
        check("R3 irq raised", int'(host_irq), 1);
        repeat (4) tick();
        check("R5 irq held", int'(host_irq), 1);
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        check("R5 irq dropped on ack", int'(host_irq), 0);
        repeat (3) tick();
        check("R5 no scoring before done", int'(score_start), 0);
        host_done = 1'b1; tick(); host_done = 1'b0;
        check("R6 start after done", int'(score_start), 1);
        check("R6 first word", int'(word_idx), 0);
        serve_scores(set_a);
        repeat (5) tick();
        check("R9 done held with switch", int'(session_done), 1);
        check("R8 tie keeps lower index", int'(led_word), 3);
        stop_sw = 1'b0; tick();
        check("R9 release restarts capture", int'(capture_en), 1);
        check("R9 done cleared", int'(session_done), 0);

        // Session 2: small mode, direct done, maximum on last word.
        push_session(set_b);
        stop_sw = 1'b1; tick(); stop_sw = 1'b0;
        check("R3 irq raised again", int'(host_irq), 1);
        host_done = 1'b1; tick(); host_done = 1'b0;
        check("R6 done skips ack", int'(score_start), 1);
        serve_scores(set_b);
        check("R8 last word wins", int'(led_word), NW - 1);
        repeat (3) tick();
        check("R9 done held after release-less idle", int'(session_done), 1);

        // Session 3: large mode, VAD trigger, maximum at word 0.
        do_reset(1'b1);
        check("R2 large mode", int'(large_mode), 1);
        check("R1 capture after reset", int'(capture_en), 1);
        stop_sw = 1'b1; tick(); stop_sw = 1'b0; tick();
        check("R4 switch ignored in large mode", int'(capture_en), 1);
        push_session(set_c);
        vad_end = 1'b1; tick(); vad_end = 1'b0;
        check("R4 vad_end raises irq", int'(host_irq), 1);
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        host_done = 1'b1; tick(); host_done = 1'b0;
        check("R6 start after ack then done", int'(score_start), 1);
        serve_scores(set_c);
        check("R8 first word wins", int'(led_word), 0);
        check("R2 mode kept", int'(large_mode), 1);
        repeat (3) tick();

        check("R7 all starts consumed", exp_idx_q.size(), 0);
        check("R8 all winners consumed", exp_led_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule